// File: doc/BRIEF.md
# Serial Display Control Register Interface

This block is the configuration front end of an LED matrix display driver. A host writes bytes over a three-wire serial link: a shift clock, a data line and an active-low enable. A register-select line must be high for the bytes to reach this block. The top bit of each byte chooses one of two 7-bit control words, and the low seven bits become that word's new value. The word changes only on the first shift-clock falling edge after the enable has returned high. Until then, and while a later byte is being shifted in, the current values keep driving the outputs.

Word 0 sets the display brightness (a PWM on-time code and a peak-current code) and the run/sleep state. Word 1 sets the data-out mode and the oscillator prescale select. The block runs on a fast system clock. The serial lines are asynchronous to it, so they are synchronized and their edges are detected in the system-clock domain. Each serial level must be held for at least SYNC_STAGES+2 system clocks.

Top module: `disp_ctrl_serial`

## Requirements
- R1: A synchronous active-low reset sets both words to zero. Afterwards pwm_level=0, peak_cur=0, sleep=1, osc_en=0, drv_en=0, dout_simul=0 and prescale_sel=0.
- R2: Data is taken most significant bit first, one bit per rising ser_clk edge, while ser_ce_n is low and reg_sel is high.
- R3: A complete byte is committed on the first ser_clk falling edge after ser_ce_n returns high. The rise of ser_ce_n alone changes no output.
- R4: A committed byte with bit 7 = 0 loads word 0. pwm_level shows bits 3..0 and peak_cur shows bits 5..4.
- R5: Bit 6 of word 0 selects run (1) or sleep (0). In sleep, sleep=1 and both osc_en and drv_en are 0. In run, sleep=0 and both enables are 1.
- R6: A committed byte with bit 7 = 1 loads word 1, and word 0 stays unchanged. dout_simul shows bit 0 (0 = serial, 1 = simultaneous) and prescale_sel shows bit 1. Bits 6..2 are stored but drive nothing.
- R7: Writing one word never changes the other. Both words keep their values while the block is asleep.
- R8: While a new byte is being shifted in, all outputs keep the values of the last committed words.
- R9: If ser_ce_n rises after any number of counted bits other than eight, the transfer is discarded and no word changes.
- R10: While reg_sel is low, ser_clk edges are neither shifted nor counted.
- R11: An output change appears exactly SYNC_STAGES+1 system clocks after the committing ser_clk falling edge reaches the input pin.
- R12: The committing falling edge may arrive in the same cycle as the ser_ce_n fall that starts the next transfer. The pending byte is still committed and the new transfer starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data, MSB first |
| ser_ce_n | input | 1 | Active-low transfer enable |
| reg_sel | input | 1 | High routes serial traffic to the control words |
| pwm_level | output | 4 | PWM brightness code from word 0 |
| peak_cur | output | 2 | Peak pixel current code from word 0 |
| sleep | output | 1 | High while word 0 requests sleep |
| osc_en | output | 1 | Internal display oscillator enable |
| drv_en | output | 1 | Pixel driver enable |
| dout_simul | output | 1 | Data-out mode, 1 = simultaneous |
| prescale_sel | output | 1 | External oscillator prescale select |

## Verification
Two events can fall in the same system clock. One is the shift-clock falling edge that commits a pending byte. The other is the enable fall that opens the next transfer and clears the bit count. The bench drives both lines in the same time step, so after synchronization they reach the edge detector together. It then judges the result two ways. The committed word must appear exactly SYNC_STAGES+1 clocks later. The following byte, shifted in under that enable, must itself commit correctly, which shows that its count began from zero. A behavioural reference model predicts every output on every clock, so a commit that is dropped, late or early shows up as a mismatch.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the serial display control interface.
// Assumes a byte of BYTE_W bits whose MSB selects one of NUM_WORDS words.
package dsc_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = BYTE_W - 1;
    localparam int NUM_WORDS = 2;
    localparam int PWM_W     = 4;
    localparam int CUR_W     = 2;
    localparam int CUR_LSB   = PWM_W;
    localparam int RUN_BIT   = PWM_W + CUR_W;
    localparam int DOUT_BIT  = 0;
    localparam int PRESC_BIT = 1;
    localparam int CNT_W     = $clog2(BYTE_W + 2);

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dsc_sync.sv
`timescale 1ns/1ps
// Module: dsc_sync
// Synchronizes a vector of asynchronous inputs into the clk domain through
// STAGES flops per bit. Assumes each input is held much longer than one
// clk period, so bits arriving one cycle apart from each other is harmless.
module dsc_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: sample the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages: pass the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dsc_shift.sv
`timescale 1ns/1ps
// Module: dsc_shift
// Detects edges on the synchronized serial lines and shifts qualified bits
// in MSB first. It counts them, latches a byte that is exactly BYTE_W bits
// long when the enable rises, and emits a one-cycle commit on the next
// shift-clock fall. Assumes synchronized inputs.
module dsc_shift
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              ce_n_s,
    input  logic              rs_s,
    output logic              commit_vld,
    output logic [BYTE_W-1:0] commit_byte
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic              sclk_q, ce_n_q;
    logic              rise, fall, ce_rise, ce_fall, shift_en;
    logic [BYTE_W-1:0] shreg, hold_q;
    logic [CNT_W-1:0]  cnt;
    logic              pend_q;

    assign rise     = sclk_s & ~sclk_q;
    assign fall     = ~sclk_s & sclk_q;
    assign ce_rise  = ce_n_s & ~ce_n_q;
    assign ce_fall  = ~ce_n_s & ce_n_q;
    assign shift_en = rise & ~ce_n_s & rs_s;

    // Keep last-cycle levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            ce_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            ce_n_q <= ce_n_s;
        end
    end

    // Shift qualified bits in, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[BYTE_W-2:0], din_s};
    end

    // Count qualified bits, saturating just above a full byte
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (ce_fall)                    cnt <= shift_en ? CNT_ONE : '0;
        else if (shift_en && cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end

    // Latch a full byte at the enable rise, release it at the commit fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else if (ce_rise) begin
            pend_q <= (cnt == CNT_FULL);
            hold_q <= shreg;
        end else if (fall && pend_q) begin
            pend_q <= 1'b0;
        end
    end

    assign commit_vld  = fall & pend_q;
    assign commit_byte = hold_q;

    // R10
    rs_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_s |=> $stable(shreg));
    // R9
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rise && cnt != CNT_FULL) |=> !pend_q);
    // R3
    one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && !ce_rise) |=> !pend_q);
endmodule

// File: rtl/dsc_words.sv
`timescale 1ns/1ps
// Module: dsc_words
// Holds the control words. A commit writes the low WORD_W bits of the
// byte into the word that the byte's MSB selects; the other word is left
// untouched. Assumes NUM_WORDS is 2 (one select bit).
module dsc_words
    import dsc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit_vld,
    input  logic [BYTE_W-1:0]                commit_byte,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words_q
);
    logic sel;
    assign sel = commit_byte[BYTE_W-1];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        // Load this word when a commit selects it
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_q[g] <= '0;
            else if (commit_vld && sel == 1'(g))
                words_q[g] <= commit_byte[WORD_W-1:0];
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_vld |=> $stable(words_q));
    // R4
    w0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && !commit_byte[BYTE_W-1])
            |=> words_q[0] == $past(commit_byte[WORD_W-1:0]));
    // R6
    w1_keeps_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && commit_byte[BYTE_W-1]) |=> $stable(words_q[0]));
endmodule

// File: rtl/disp_ctrl_serial.sv
`timescale 1ns/1ps
// Module: disp_ctrl_serial
// Serial configuration front end of an LED matrix driver. It synchronizes
// the serial lines, assembles bytes, commits them into two control words
// and decodes the word fields onto outputs. Assumes every serial level is
// held for at least SYNC_STAGES+2 clk cycles.
module disp_ctrl_serial
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             ser_ce_n,
    input  logic             reg_sel,
    output logic [PWM_W-1:0] pwm_level,
    output logic [CUR_W-1:0] peak_cur,
    output logic             sleep,
    output logic             osc_en,
    output logic             drv_en,
    output logic             dout_simul,
    output logic             prescale_sel
);
    logic [3:0]                       pins_s;
    logic                             commit_vld;
    logic [BYTE_W-1:0]                commit_byte;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic                             awake;
    logic                             unused_w1_hi;

    dsc_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (4),
        .RST_VAL(4'b0010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ser_clk, ser_din, ser_ce_n, reg_sel}),
        .q    (pins_s)
    );

    dsc_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[3]),
        .din_s      (pins_s[2]),
        .ce_n_s     (pins_s[1]),
        .rs_s       (pins_s[0]),
        .commit_vld (commit_vld),
        .commit_byte(commit_byte)
    );

    dsc_words u_words (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_vld (commit_vld),
        .commit_byte(commit_byte),
        .words_q    (words)
    );

    // Field decode of the active words
    assign pwm_level    = words[0][PWM_W-1:0];
    assign peak_cur     = words[0][CUR_LSB +: CUR_W];
    assign awake        = words[0][RUN_BIT];
    assign sleep        = ~awake;
    assign osc_en       = awake;
    assign drv_en       = awake;
    assign dout_simul   = words[1][DOUT_BIT];
    assign prescale_sel = words[1][PRESC_BIT];
    assign unused_w1_hi = ^words[1][WORD_W-1:PRESC_BIT+1];

    // R5
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!osc_en && !drv_en));
endmodule

// File: tb/disp_ctrl_serial_test.sv
`timescale 1ns/1ps
module disp_ctrl_serial_test;
    localparam int HALF = 6;
    localparam int LAT  = 3;    // SYNC_STAGES + 1 at the default

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_din = 1'b0, ser_ce_n = 1'b1, reg_sel = 1'b0;
    logic [3:0] pwm_level;
    logic [1:0] peak_cur;
    logic sleep, osc_en, drv_en, dout_simul, prescale_sel;

    int checks = 0, errors = 0;
    int exp_w0 = 0, exp_w1 = 0;
    bit bq[$];
    bit pend = 1'b0;
    logic [7:0] pend_byte = '0;
    bit run_cmp = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    disp_ctrl_serial uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_ce_n(ser_ce_n), .reg_sel(reg_sel), .pwm_level(pwm_level),
        .peak_cur(peak_cur), .sleep(sleep), .osc_en(osc_en), .drv_en(drv_en),
        .dout_simul(dout_simul), .prescale_sel(prescale_sel)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_outputs(input string tag);
        bit run;
        run = exp_w0[6];
        chk(tag, "pwm_level", int'(pwm_level), exp_w0 & 15);
        chk(tag, "peak_cur", int'(peak_cur), (exp_w0 >> 4) & 3);
        chk(tag, "sleep", int'(sleep), int'(!run));
        chk(tag, "osc_en", int'(osc_en), int'(run));
        chk(tag, "drv_en", int'(drv_en), int'(run));
        chk(tag, "dout_simul", int'(dout_simul), exp_w1 & 1);
        chk(tag, "prescale_sel", int'(prescale_sel), (exp_w1 >> 1) & 1);
    endtask

    // Reference comparison on every clock, away from the active edge
    always @(negedge clk) if (run_cmp) chk_outputs(cur_req);

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic apply(input logic [7:0] b);
        if (b[7]) exp_w1 = int'(b[6:0]);
        else      exp_w0 = int'(b[6:0]);
    endtask

    task automatic do_rise();
        ser_clk = 1'b1;
        if (!ser_ce_n && reg_sel) bq.push_back(ser_din);
        step(HALF);
    endtask

    // Fall, optionally with the enable dropping in the same time step
    task automatic do_fall(input bit with_ce_fall);
        bit c;
        c = pend;
        ser_clk = 1'b0;
        if (with_ce_fall) begin ser_ce_n = 1'b0; bq.delete(); end
        pend = 1'b0;
        if (c) begin
            step(LAT);
            apply(pend_byte);
            step(HALF - LAT);
        end else step(HALF);
    endtask

    task automatic ce_low();
        ser_ce_n = 1'b0;
        bq.delete();
        step(HALF);
    endtask

    task automatic ce_high();
        ser_ce_n = 1'b1;
        pend = (bq.size() == 8);
        if (pend) for (int i = 0; i < 8; i++) pend_byte[7-i] = bq[i];
        step(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            ser_din = (i < 8) ? b[7-i] : 1'b0;
            do_rise();
            do_fall(1'b0);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        reg_sel = 1'b1;
        ce_low();
        send_bits(b, 8);
        ce_high();
        do_rise();
        do_fall(1'b0);
    endtask

    task automatic do_reset();
        run_cmp = 1'b0;
        rst_n = 1'b0;
        ser_clk = 1'b0; ser_ce_n = 1'b1; reg_sel = 1'b0; ser_din = 1'b0;
        exp_w0 = 0; exp_w1 = 0; bq.delete(); pend = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(1);
        @(negedge clk);
        chk_outputs("R1");
        step(1);
        run_cmp = 1'b1;
    endtask

    initial begin
        do_reset();

        cur_req = "R4"; write_byte(8'h6B);
        cur_req = "R2"; write_byte(8'h71);
        cur_req = "R6"; write_byte(8'h83);
        cur_req = "R5"; write_byte(8'h2F);
        cur_req = "R7"; write_byte(8'h82); write_byte(8'h40);
        cur_req = "R8"; write_byte(8'h55);
        cur_req = "R3"; reg_sel = 1'b1; ce_low(); send_bits(8'h0F, 8); ce_high();
        step(20); do_rise(); do_fall(1'b0);
        cur_req = "R9";
        ce_low(); send_bits(8'h7E, 7); ce_high(); do_rise(); do_fall(1'b0);
        ce_low(); send_bits(8'hC1, 9); ce_high(); do_rise(); do_fall(1'b0);
        cur_req = "R10";
        reg_sel = 1'b0; ce_low(); send_bits(8'h5F, 8); ce_high(); do_rise(); do_fall(1'b0);
        reg_sel = 1'b1; ce_low(); send_bits(8'h3C, 4);
        reg_sel = 1'b0; send_bits(8'hFF, 3);
        reg_sel = 1'b1; send_bits(8'hC0, 4);
        ce_high(); do_rise(); do_fall(1'b0);
        cur_req = "R11"; write_byte(8'h81);
        cur_req = "R12";
        reg_sel = 1'b1; ce_low(); send_bits(8'h4A, 8); ce_high(); do_rise();
        do_fall(1'b1);
        send_bits(8'h82, 8); ce_high(); do_rise(); do_fall(1'b0);
        step(4);
        cur_req = "R1"; write_byte(8'h7F);
        do_reset();
        step(4);
        run_cmp = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule